// File: doc/BRIEF.md
# Stretchable External Data Bus Sequencer

This block runs one external data-memory read or write on a multiplexed address/data bus of the classic 8-bit controller kind. A machine cycle is four clocks. Each access lasts two machine cycles plus a programmable stretch count of 0 to 7, so an access takes 2 to 9 machine cycles. The read or write strobe widens with the stretch count, which lets fast memories run at full speed and slow peripherals sit on the same bus without extra logic.

The core pulses `start` for one clock with the direction, the address and the write data. The block latches all of these and then drives the bus pins. The low address byte goes out on the port 0 bus under an address-latch pulse. The bus then turns around to carry write data, or it is released so a read can be sampled. The high address byte is driven on port 2. In short-address mode the high byte comes from the port 2 latch value instead of the address input. Read data is captured into a register, and a one-clock `done` marks the last clock of the access. The stretch count sits in a small control register that resets to 1.

Top module: `xmem_stretch_seq`

## Requirements
Clock k of an access means the k-th clock after the edge that accepted `start`, counting from k=0. S is the stretch value latched at that edge. SE is the last strobe clock: 5 when S=0, and 3+4·S otherwise.
- R1: The stretch register reads 1 on `stretch_cfg` after reset. It loads `cfg_stretch` on a clock where `cfg_wr`=1 and holds its value otherwise.
- R2: An access lasts 4·(2+S) clocks. `done` is 1 only on its last clock, k=4·(2+S)−1. The clock after that is idle.
- R3: `ale` is 1 on clocks k=0 and 1 and 0 for the rest of the access and in idle. `ale` and `psen_n` are 1 while `rst_n` is low, and `psen_n` stays 1 at all times.
- R4: The active strobe is low on clocks 4 to SE. That is 2 clocks for S=0 and 4·S clocks otherwise. `rd_n` is the strobe for a read (`rd_sel`=1) and `wr_n` for a write. The other strobe stays 1.
- R5: `p0_oe`=1 and `p0_out` carries address bits 7:0 on clocks 0 to 2 when S=0, or on clocks 0 to 3 when S>0.
- R6: For a write, `p0_out` carries the write data with `p0_oe`=1 from the clock after the address window through SE+1 (S=0) or SE+2 (S>0). For a read, and on every other clock, `p0_oe`=0.
- R7: During an access `p2_out` carries the latched high address. That is `addr[15:8]`, or `p2_latch` when `short_addr`=1. In idle `p2_out` follows `p2_latch`.
- R8: A read captures `p0_in` at the end of clock SE into `rdata`. `rdata` keeps that value through later writes until the next read.
- R9: Changes to the inputs or to the stretch register during an access do not alter that access. A new stretch value applies from the next access on.
- R10: `start` during an access is ignored. No second access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write enable of the stretch register |
| cfg_stretch | input | 3 | New stretch value |
| stretch_cfg | output | 3 | Current stretch register value |
| start | input | 1 | One-clock request for an access |
| rd_sel | input | 1 | 1 = read, 0 = write |
| short_addr | input | 1 | Take the high address byte from `p2_latch` |
| addr | input | 16 | Access address |
| p2_latch | input | 8 | Port 2 latch value |
| wdata | input | 8 | Write data |
| p0_in | input | 8 | Port 0 pin input |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, held inactive |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| p0_out | output | 8 | Port 0 drive value |
| p0_oe | output | 1 | Port 0 output enable |
| p2_out | output | 8 | Port 2 high address |
| rdata | output | 8 | Captured read data |
| done | output | 1 | Last clock of an access |

## Verification
A wrong count or a wrong latched stretch shows on the strobe edges and on `done` within the same access. The strobe rises a multiple of four clocks early or late, and `done` comes at the wrong clock. A wrong bus turnaround shows as `p0_oe` on the wrong clock, either one clock early or late at the address/data boundary, or at the write-data hold after the strobe rises. A read captured on the wrong clock shows in `rdata` once the access has ended. The bench drives the expected read value on `p0_in` only during the last strobe clock. An access started from a bad idle state, or a second access started by a stray `start`, shows as bus activity in the idle clock after `done`.

// File: rtl/xs_pkg.sv
package xs_pkg;

  localparam int XS_BYTE_W = 8;
  localparam int XS_STR_W  = 3;
  localparam int XS_PH     = 4;
  localparam int XS_MAX_LEN = XS_PH * (2 + (1 << XS_STR_W) - 1);
  localparam int XS_CNT_W  = $clog2(XS_MAX_LEN);

  typedef struct packed {
    logic                 rd;
    logic [XS_BYTE_W-1:0] ahi;
    logic [XS_BYTE_W-1:0] alo;
    logic [XS_BYTE_W-1:0] wd;
  } xs_req_t;

  function automatic int unsigned xs_len(input int unsigned s);
    return XS_PH * (2 + s);
  endfunction

  function automatic int unsigned xs_addr_last(input int unsigned s);
    return (s == 0) ? (XS_PH / 2) : (XS_PH - 1);
  endfunction

  function automatic int unsigned xs_strobe_last(input int unsigned s);
    return (s == 0) ? (XS_PH + 1) : (XS_PH + XS_PH * s - 1);
  endfunction

  function automatic int unsigned xs_wd_last(input int unsigned s);
    return xs_strobe_last(s) + ((s == 0) ? 1 : 2);
  endfunction

endpackage

// File: rtl/xs_cfg.sv
module xs_cfg
  import xs_pkg::*;
#(
  parameter int STR_W       = XS_STR_W,
  parameter int STRETCH_RST = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [STR_W-1:0] wr_val,
  output logic [STR_W-1:0] stretch_q
);

  logic [STR_W-1:0] stretch_n;

  always_comb begin
    stretch_n = stretch_q;
    if (wr_en) stretch_n = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stretch_q <= STR_W'(STRETCH_RST);
    else        stretch_q <= stretch_n;
  end

endmodule

// File: rtl/xs_timer.sv
module xs_timer
  import xs_pkg::*;
#(
  parameter int STR_W = XS_STR_W,
  parameter int CNT_W = XS_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  xs_req_t          req_in,
  input  logic [STR_W-1:0] stretch_in,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic             at_end,
  output xs_req_t          req_q,
  output logic [STR_W-1:0] str_q
);

  logic             active_n;
  logic [CNT_W-1:0] cnt_n;
  xs_req_t          req_n;
  logic [STR_W-1:0] str_n;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'(xs_len(32'(str_q)) - 1);
  assign at_end   = active && (cnt == last_cnt);

  always_comb begin
    active_n = active;
    cnt_n    = cnt;
    req_n    = req_q;
    str_n    = str_q;
    if (!active) begin
      if (start) begin
        active_n = 1'b1;
        cnt_n    = '0;
        req_n    = req_in;
        str_n    = stretch_in;
      end
    end else if (at_end) begin
      active_n = 1'b0;
      cnt_n    = '0;
    end else begin
      cnt_n = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      req_q  <= '0;
      str_q  <= '0;
    end else begin
      active <= active_n;
      cnt    <= cnt_n;
      req_q  <= req_n;
      str_q  <= str_n;
    end
  end

endmodule

// File: rtl/xs_decode.sv
module xs_decode
  import xs_pkg::*;
#(
  parameter int STR_W  = XS_STR_W,
  parameter int CNT_W  = XS_CNT_W,
  parameter int BYTE_W = XS_BYTE_W
) (
  input  logic              in_reset,
  input  logic              active,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              at_end,
  input  xs_req_t           req_q,
  input  logic [STR_W-1:0]  str_q,
  input  logic [BYTE_W-1:0] p2_latch,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [BYTE_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [BYTE_W-1:0] p2_out,
  output logic              done,
  output logic              cap_en
);

  logic [CNT_W-1:0] ale_end;
  logic [CNT_W-1:0] addr_end;
  logic [CNT_W-1:0] strb_beg;
  logic [CNT_W-1:0] strb_end;
  logic [CNT_W-1:0] wd_end;
  logic             in_addr;
  logic             in_strb;
  logic             in_wd;

  assign ale_end  = CNT_W'(XS_PH / 2 - 1);
  assign addr_end = CNT_W'(xs_addr_last(32'(str_q)));
  assign strb_beg = CNT_W'(XS_PH);
  assign strb_end = CNT_W'(xs_strobe_last(32'(str_q)));
  assign wd_end   = CNT_W'(xs_wd_last(32'(str_q)));

  always_comb begin
    in_addr = active && (cnt <= addr_end);
    in_strb = active && (cnt >= strb_beg) && (cnt <= strb_end);
    in_wd   = active && !req_q.rd && (cnt > addr_end) && (cnt <= wd_end);

    ale    = in_reset || (active && (cnt <= ale_end));
    rd_n   = !(in_strb && req_q.rd);
    wr_n   = !(in_strb && !req_q.rd);
    p0_oe  = in_addr || in_wd;
    p0_out = '0;
    if (in_addr)    p0_out = req_q.alo;
    else if (in_wd) p0_out = req_q.wd;
    p2_out = active ? req_q.ahi : p2_latch;
    done   = at_end;
    cap_en = in_strb && req_q.rd && (cnt == strb_end);
  end

endmodule

// File: rtl/xs_rcap.sv
module xs_rcap
  import xs_pkg::*;
#(
  parameter int BYTE_W = XS_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] bus_in,
  output logic [BYTE_W-1:0] data_q
);

  logic [BYTE_W-1:0] data_n;

  always_comb begin
    data_n = data_q;
    if (cap_en) data_n = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_n;
  end

endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq
  import xs_pkg::*;
#(
  parameter int BYTE_W      = XS_BYTE_W,
  parameter int STR_W       = XS_STR_W,
  parameter int STRETCH_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [STR_W-1:0]  cfg_stretch,
  output logic [STR_W-1:0]  stretch_cfg,
  input  logic              start,
  input  logic              rd_sel,
  input  logic              short_addr,
  input  logic [2*BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] p2_latch,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] p0_in,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [BYTE_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [BYTE_W-1:0] p2_out,
  output logic [BYTE_W-1:0] rdata,
  output logic              done
);

  localparam int CNT_W = XS_CNT_W;

  xs_req_t          req_in;
  xs_req_t          req_q;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             at_end;
  logic [STR_W-1:0] str_q;
  logic             cap_en;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  always_comb begin
    req_in.rd  = rd_sel;
    req_in.ahi = short_addr ? p2_latch : addr[2*BYTE_W-1:BYTE_W];
    req_in.alo = addr[BYTE_W-1:0];
    req_in.wd  = wdata;
  end

  assign psen_n = 1'b1;

  xs_cfg #(.STR_W(STR_W), .STRETCH_RST(STRETCH_RST)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .wr_val    (cfg_stretch),
    .stretch_q (stretch_cfg)
  );

  xs_timer #(.STR_W(STR_W), .CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .req_in     (req_in),
    .stretch_in (stretch_cfg),
    .active     (active),
    .cnt        (cnt),
    .at_end     (at_end),
    .req_q      (req_q),
    .str_q      (str_q)
  );

  xs_decode #(.STR_W(STR_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_dec (
    .in_reset (!run_q),
    .active   (active),
    .cnt      (cnt),
    .at_end   (at_end),
    .req_q    (req_q),
    .str_q    (str_q),
    .p2_latch (p2_latch),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .p0_out   (p0_out),
    .p0_oe    (p0_oe),
    .p2_out   (p2_out),
    .done     (done),
    .cap_en   (cap_en)
  );

  xs_rcap #(.BYTE_W(BYTE_W)) u_rcap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .bus_in (p0_in),
    .data_q (rdata)
  );

endmodule

// File: rtl/xmem_stretch_seq_chk.sv
module xmem_stretch_seq_chk #(
  parameter int BYTE_W = 8,
  parameter int STR_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [STR_W-1:0]  stretch_cfg,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              p0_oe,
  input logic [BYTE_W-1:0] rdata,
  input logic              done
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R4

  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_DONE_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n)); // R4

  AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !p0_oe); // R6

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(stretch_cfg)); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_n) |-> $stable(rdata)); // R8

endmodule

bind xmem_stretch_seq xmem_stretch_seq_chk #(.BYTE_W(BYTE_W), .STR_W(STR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .stretch_cfg (stretch_cfg),
  .ale         (ale),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .p0_oe       (p0_oe),
  .rdata       (rdata),
  .done        (done)
);

// File: tb/xmem_stretch_seq_tb.sv
module xmem_stretch_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [2:0]  cfg_stretch;
  logic [2:0]  stretch_cfg;
  logic        start;
  logic        rd_sel;
  logic        short_addr;
  logic [15:0] addr;
  logic [7:0]  p2_latch;
  logic [7:0]  wdata;
  logic [7:0]  p0_in;
  logic        ale, psen_n, rd_n, wr_n, p0_oe, done;
  logic [7:0]  p0_out, p2_out, rdata;

  int checks = 0;
  int failures = 0;
  logic [7:0] last_rd;

  always #4 clk = ~clk;

  xmem_stretch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_stretch(cfg_stretch),
    .stretch_cfg(stretch_cfg), .start(start), .rd_sel(rd_sel),
    .short_addr(short_addr), .addr(addr), .p2_latch(p2_latch),
    .wdata(wdata), .p0_in(p0_in), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
    .p2_out(p2_out), .rdata(rdata), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_stretch(input logic [2:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_stretch = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R1", "stretch_cfg after write", 16'(stretch_cfg), 16'(v));
  endtask

  // One access with full per-clock checks.
  // cfg_at / start_at: clock index at which to poke the stretch register or start (-1 = none).
  task automatic run_acc(input logic rd, input logic sh, input logic [15:0] a,
                         input logic [7:0] wd, input logic [7:0] rv,
                         input logic [7:0] p2l, input int cfg_at,
                         input logic [2:0] cfg_v, input int start_at);
    int s, len, se, al, wl;
    logic [7:0] hi;
    s   = int'(stretch_cfg);
    len = 4 * (2 + s);
    se  = (s == 0) ? 5 : 3 + 4 * s;
    al  = (s == 0) ? 2 : 3;
    wl  = se + ((s == 0) ? 1 : 2);
    hi  = sh ? p2l : a[15:8];
    @(negedge clk);
    rd_sel = rd; short_addr = sh; addr = a; wdata = wd; p2_latch = p2l;
    p0_in = ~rv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      logic strb, oe_e;
      logic [7:0] p0_e;
      strb = (k >= 4) && (k <= se);
      oe_e = (k <= al) || (!rd && (k > al) && (k <= wl));
      p0_e = (k <= al) ? a[7:0] : wd;
      chk("R3", "ale", 16'(ale), 16'(k <= 1));
      chk("R3", "psen_n", 16'(psen_n), 16'd1);
      chk("R4", "rd_n", 16'(rd_n), 16'(!(strb && rd)));
      chk("R4", "wr_n", 16'(wr_n), 16'(!(strb && !rd)));
      chk(k <= al ? "R5" : "R6", "p0_oe", 16'(p0_oe), 16'(oe_e));
      if (oe_e) chk(k <= al ? "R5" : "R6", "p0_out", 16'(p0_out), 16'(p0_e));
      chk("R7", "p2_out", 16'(p2_out), 16'(hi));
      chk("R2", "done", 16'(done), 16'(k == len - 1));
      cfg_wr = 1'b0;
      // R9: disturb inputs during the access
      if (k == 0) begin
        addr = ~a; wdata = ~wd; p2_latch = ~p2l; rd_sel = ~rd; short_addr = ~sh;
      end
      if (k == cfg_at) begin cfg_wr = 1'b1; cfg_stretch = cfg_v; end
      start = (k == start_at);
      p0_in = (k == se) ? rv : ~rv;
      @(negedge clk);
    end
    start = 1'b0; cfg_wr = 1'b0;
    chk("R2", "idle done", 16'(done), 16'd0);
    chk("R10", "idle ale", 16'(ale), 16'd0);
    chk("R10", "idle strobes", 16'({rd_n, wr_n}), 16'b11);
    chk("R10", "idle p0_oe", 16'(p0_oe), 16'd0);
    chk("R7", "idle p2_out", 16'(p2_out), 16'(p2_latch));
    if (rd) last_rd = rv;
    chk("R8", "rdata", 16'(rdata), 16'(last_rd));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_stretch = 3'd0; start = 1'b0;
    rd_sel = 1'b0; short_addr = 1'b0; addr = '0; p2_latch = 8'h00;
    wdata = '0; p0_in = '0; last_rd = 8'h00;
    repeat (3) @(negedge clk);
    chk("R3", "ale in reset", 16'(ale), 16'd1);
    chk("R3", "psen_n in reset", 16'(psen_n), 16'd1);
    chk("R1", "stretch reset", 16'(stretch_cfg), 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "ale idle", 16'(ale), 16'd0);
    chk("R4", "idle strobes", 16'({rd_n, wr_n}), 16'b11);
    chk("R8", "rdata reset", 16'(rdata), 16'd0);
    chk("R1", "stretch held", 16'(stretch_cfg), 16'd1);
  endtask

  task automatic t_default_read;   // R1 default stretch gives 12-clock access
    run_acc(1'b1, 1'b0, 16'h12A5, 8'h00, 8'h3C, 8'h77, -1, 3'd0, -1);
  endtask

  task automatic t_fast_write;     // R4 R6 stretch 0
    set_stretch(3'd0);
    run_acc(1'b0, 1'b0, 16'hBEEF, 8'h5A, 8'h00, 8'h11, -1, 3'd0, -1);
  endtask

  task automatic t_short_addr;     // R7 high byte from latch
    set_stretch(3'd2);
    run_acc(1'b0, 1'b1, 16'hC381, 8'hE7, 8'h00, 8'h9D, -1, 3'd0, -1);
    run_acc(1'b1, 1'b1, 16'h4402, 8'h00, 8'hA1, 8'h2B, -1, 3'd0, -1);
  endtask

  task automatic t_mid_cfg;        // R9 stretch change during access
    set_stretch(3'd2);
    run_acc(1'b1, 1'b0, 16'h0F0F, 8'h00, 8'h66, 8'h01, 6, 3'd5, -1);
    chk("R9", "new stretch stored", 16'(stretch_cfg), 16'd5);
    run_acc(1'b0, 1'b0, 16'hF00F, 8'hC4, 8'h00, 8'h02, -1, 3'd0, -1);
  endtask

  task automatic t_start_ignored;  // R10
    set_stretch(3'd3);
    run_acc(1'b0, 1'b0, 16'h2468, 8'h13, 8'h00, 8'h40, -1, 3'd0, 5);
    run_acc(1'b1, 1'b0, 16'h1357, 8'h00, 8'h8E, 8'h40, -1, 3'd0, 19);
  endtask

  task automatic t_sweep;          // R2 R4 R5 R6 R8 for every stretch
    for (int s = 0; s < 8; s++) begin
      set_stretch(3'(s));
      run_acc(1'b1, 1'b0, 16'(16'hA000 + s * 16'h0111), 8'h00, 8'(8'h20 + s), 8'h55, -1, 3'd0, -1);
      run_acc(1'b0, 1'b0, 16'(16'h5000 + s * 16'h0203), 8'(8'h90 + s), 8'h00, 8'hAA, -1, 3'd0, -1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_default_read();
    t_fast_write();
    t_short_addr();
    t_mid_cfg();
    t_start_ignored();
    t_sweep();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule